// File: doc/BRIEF.md
# ROM Configuration and Wait-State Access Controller

This block holds the configuration state of an on-chip ROM array and uses it to time accesses to that array. A register port writes and reads three registers: a configuration word and two base-address halves. The configuration word carries a wait-state code, an address-space code, a sticky lock bit, a stop bit, an emulation (force-external) bit and a read-only boot bit. Reset values come from module parameters, which stand in for options fixed at manufacture.

Writes to the protected fields are qualified. The lock bit may be set once after reset and then stays set until the next reset. While it is set, the wait-state code, the address-space code and both base-address halves refuse writes. These fields also refuse writes unless the stop bit is set. The qualifiers are taken from the register values held before the write, so a write that sets the lock still updates the protected fields in that same write.

The access side accepts a request that carries an address-hit flag, a program/data flag and a bootstrap-vector flag. The ROM claims the access only when the address hits, emulation is off, the address-space code allows the access type, and a bootstrap vector fetch is allowed by the boot options. A claimed access moves through the states IDLE, BUSY and ACK. IDLE goes to ACK directly for the fast code. It goes to BUSY for every other code, and BUSY goes to ACK when its down-counter reaches zero. ACK always returns to IDLE. The acknowledge is high for exactly one cycle, placed at the clock position given by the wait-state code.

Top module: `rom_cfg_waitctl`

## Requirements
- R1: After reset the configuration word reads back the parameter reset values. With the default parameters every field is zero, and both base-address halves read zero.
- R2: The wait-state code, held in configuration bits [7:6], takes a written value only when the lock bit (bit 1) is 0 and the stop bit (bit 0) is 1. Any other write leaves it unchanged.
- R3: Writing 1 to the lock bit sets it. Writing 0 never clears it. Only reset clears it.
- R4: While the lock is set, writes to the address-space code (bits [5:4]), the wait-state code and both base-address halves (select 1 = high half, select 2 = low half) have no effect.
- R5: While the stop bit is 0, writes to the address-space code and to both base-address halves have no effect.
- R6: The boot bit (bit 3) is read-only. A bootstrap vector fetch is acknowledged only when the boot bit is 0 and the stop bit was 0 at reset. With the stop bit 1 at reset, vector fetches are never acknowledged, while ordinary fetches still are.
- R7: When the address-space code has its low bit 1, data accesses are not acknowledged and program accesses are. When the low bit is 0, both are acknowledged. The high bit has no effect.
- R8: While the emulation bit (bit 2) is 1, no access is acknowledged.
- R9: A claimed access is acknowledged in clock N of the transfer, where the request cycle counts as clock 1. N is 3, 4, 5 or 2 for wait codes 00, 01, 10 or 11.
- R10: The acknowledge is a one-cycle pulse. No new request is accepted before it. The wait code in force is the one captured when the request is accepted, so a write during the access does not change that access.
- R11: Reads return every field at all times, whatever the lock and stop bits hold. Select 0 returns the configuration word with the wait code at bits [7:6], the address-space code at [5:4], boot at 3, emulation at 2, lock at 1 and stop at 0. Select 3 returns zero.
- R12: A request with the address-hit input low is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for a write |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Register select for a read |
| rd_data | output | DATA_W | Read data (combinational) |
| acc_req | input | 1 | Access request, held until acknowledged |
| acc_hit | input | 1 | Address falls inside the ROM window |
| acc_prog | input | 1 | 1 = program access, 0 = data access |
| acc_vec | input | 1 | Access is a bootstrap vector fetch during reset |
| acc_ack | output | 1 | One-cycle acknowledge |

## Verification
The assertions assume that a requester holds acc_req and its qualifiers steady from the request cycle until the acknowledge, and drops acc_req in the cycle after the acknowledge. They also assume register writes are single-cycle strobes. The bench drives every input on the falling edge. Each access task raises the request and holds it, then lowers it on the first falling edge that shows the acknowledge. For accesses the ROM does not claim, the task lowers the request after a fixed window. The one mid-access write is timed to land after acceptance and before the acknowledge.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

    typedef struct packed {
        logic [1:0] wt;
        logic [1:0] aspc;
        logic       boot;
        logic       emul;
        logic       lock;
        logic       stop;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {
        SEL_CFG = 2'd0,
        SEL_BHI = 2'd1,
        SEL_BLO = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_ACK  = 2'd2
    } xfer_st_e;

    localparam int CNT_W = 2;

    // Clocks per transfer for each wait code.
    function automatic int unsigned xfer_clocks(input logic [1:0] code);
        unique case (code)
            2'b00:   return 3;
            2'b01:   return 4;
            2'b10:   return 5;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/rcw_cfg_regs.sv
module rcw_cfg_regs
    import rcw_pkg::*;
#(
    parameter int         DATA_W   = 16,
    parameter logic       BOOT_RST = 1'b0,
    parameter logic       LOCK_RST = 1'b0,
    parameter logic [1:0] ASPC_RST = 2'b00,
    parameter logic [1:0] WAIT_RST = 2'b00,
    parameter logic       STOP_RST = 1'b0,
    parameter logic       EMUL_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output cfg_t              cfg_o
);

    localparam int PAD_W = DATA_W - CFG_W;

    cfg_t              cfg_q;
    logic [DATA_W-1:0] bhi_q;
    logic [DATA_W-1:0] blo_q;
    logic              prot_open;

    // Protected fields open only when unlocked and stopped (pre-write values).
    assign prot_open = !cfg_q.lock && cfg_q.stop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.wt   <= WAIT_RST;
            cfg_q.aspc <= ASPC_RST;
            cfg_q.boot <= BOOT_RST;
            cfg_q.emul <= EMUL_RST;
            cfg_q.lock <= LOCK_RST;
            cfg_q.stop <= STOP_RST;
            bhi_q      <= '0;
            blo_q      <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CFG: begin
                    cfg_q.stop <= wr_data[0];
                    cfg_q.emul <= wr_data[2];
                    if (wr_data[1]) begin
                        cfg_q.lock <= 1'b1;
                    end
                    if (prot_open) begin
                        cfg_q.aspc <= wr_data[5:4];
                        cfg_q.wt   <= wr_data[7:6];
                    end
                end
                SEL_BHI: begin
                    if (prot_open) begin
                        bhi_q <= wr_data;
                    end
                end
                SEL_BLO: begin
                    if (prot_open) begin
                        blo_q <= wr_data;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_CFG: rd_data = {{PAD_W{1'b0}}, cfg_q};
            SEL_BHI: rd_data = bhi_q;
            SEL_BLO: rd_data = blo_q;
            default: rd_data = '0;
        endcase
    end

    assign cfg_o = cfg_q;

    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |=> cfg_q.lock);

    a_r2_wait_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_open |=> $stable(cfg_q.wt));

    a_r4_base_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |=> ($stable(bhi_q) && $stable(blo_q) && $stable(cfg_q.aspc)));

    a_r5_aspc_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.stop |=> ($stable(cfg_q.aspc) && $stable(bhi_q) && $stable(blo_q)));

    a_r6_boot_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(cfg_q.boot));

endmodule

// File: rtl/rcw_claim.sv
module rcw_claim
    import rcw_pkg::*;
#(
    parameter logic STOP_AT_RST = 1'b0
) (
    input  cfg_t cfg_i,
    input  logic hit_i,
    input  logic prog_i,
    input  logic vec_i,
    output logic claim_o
);

    logic space_ok;
    logic vec_ok;
    logic boot_allow;

    // Bootstrap override follows the stop value held at reset.
    generate
        if (STOP_AT_RST) begin : g_boot_off
            assign boot_allow = 1'b0;
        end else begin : g_boot_on
            assign boot_allow = !cfg_i.boot;
        end
    endgenerate

    always_comb begin
        space_ok = prog_i || !cfg_i.aspc[0];
        vec_ok   = !vec_i || boot_allow;
        claim_o  = hit_i && !cfg_i.emul && space_ok && vec_ok;
    end

endmodule

// File: rtl/rcw_access_fsm.sv
module rcw_access_fsm
    import rcw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       claim_i,
    input  logic [1:0] wt_i,
    output logic       ack_o
);

    xfer_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept;
    logic [CNT_W-1:0] load_val;

    assign accept   = (st_q == ST_IDLE) && req_i && claim_i;
    assign load_val = CNT_W'(xfer_clocks(wt_i) - 3);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (xfer_clocks(wt_i) == 2) begin
                        st_d = ST_ACK;
                    end else begin
                        st_d  = ST_BUSY;
                        cnt_d = load_val;
                    end
                end
            end
            ST_BUSY: begin
                if (cnt_q == '0) begin
                    st_d = ST_ACK;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ACK: begin
                st_d = ST_IDLE;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        ack_o = (st_q == ST_ACK);
    end

    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    a_r9_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (($past(st_q) == ST_BUSY && $past(cnt_q) == '0) ||
                   ($past(st_q) == ST_IDLE && $past(wt_i) == 2'b11)));

    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY && cnt_q != '0) |=> (st_q == ST_BUSY));

endmodule

// File: rtl/rom_cfg_waitctl.sv
module rom_cfg_waitctl
    import rcw_pkg::*;
#(
    parameter int         DATA_W   = 16,
    parameter logic       BOOT_RST = 1'b0,
    parameter logic       LOCK_RST = 1'b0,
    parameter logic [1:0] ASPC_RST = 2'b00,
    parameter logic [1:0] WAIT_RST = 2'b00,
    parameter logic       STOP_RST = 1'b0,
    parameter logic       EMUL_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              acc_req,
    input  logic              acc_hit,
    input  logic              acc_prog,
    input  logic              acc_vec,
    output logic              acc_ack
);

    cfg_t cfg;
    logic claim;

    rcw_cfg_regs #(
        .DATA_W  (DATA_W),
        .BOOT_RST(BOOT_RST),
        .LOCK_RST(LOCK_RST),
        .ASPC_RST(ASPC_RST),
        .WAIT_RST(WAIT_RST),
        .STOP_RST(STOP_RST),
        .EMUL_RST(EMUL_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .rd_sel (rd_sel),
        .rd_data(rd_data),
        .cfg_o  (cfg)
    );

    rcw_claim #(
        .STOP_AT_RST(STOP_RST)
    ) u_claim (
        .cfg_i  (cfg),
        .hit_i  (acc_hit),
        .prog_i (acc_prog),
        .vec_i  (acc_vec),
        .claim_o(claim)
    );

    rcw_access_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (acc_req),
        .claim_i(claim),
        .wt_i   (cfg.wt),
        .ack_o  (acc_ack)
    );

    a_r8_emul_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.emul |-> !claim);

    a_r7_data_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.aspc[0] && !acc_prog) |-> !claim);

    a_r12_miss_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_hit |-> !claim);

endmodule

// File: tb/sim_rom_cfg_waitctl.sv
module sim_rom_cfg_waitctl;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_sel = 2'd0;
    logic [DW-1:0] rd_data, rd_data1;
    logic          acc_req = 1'b0;
    logic          acc_hit = 1'b0;
    logic          acc_prog = 1'b0;
    logic          acc_vec = 1'b0;
    logic          acc_ack, acc_ack1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rom_cfg_waitctl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .acc_req(acc_req), .acc_hit(acc_hit), .acc_prog(acc_prog),
        .acc_vec(acc_vec), .acc_ack(acc_ack)
    );

    rom_cfg_waitctl #(.DATA_W(DW), .STOP_RST(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data1),
        .acc_req(acc_req), .acc_hit(acc_hit), .acc_prog(acc_prog),
        .acc_vec(acc_vec), .acc_ack(acc_ack1)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read_check(input logic [1:0] sel, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        rd_sel = sel;
        #1;
        check(rd_data == exp, tag, int'(rd_data), int'(exp));
    endtask

    // Runs one access; k0/k1 are the falling-edge indices of the first ack
    // (0 = none). Ack at index k means clock k+1 of the transfer.
    task automatic run_access(input bit hit, input bit prog, input bit vec,
                              input bit mid_wr, input logic [DW-1:0] mid_d,
                              output int k0, output int k1, output int hi0);
        k0 = 0; k1 = 0; hi0 = 0;
        @(negedge clk);
        acc_req = 1'b1; acc_hit = hit; acc_prog = prog; acc_vec = vec;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (mid_wr && k == 1) begin
                wr_en = 1'b1; wr_sel = 2'd0; wr_data = mid_d;
            end
            if (k == 2) wr_en = 1'b0;
            if (acc_ack) begin
                hi0++;
                if (k0 == 0) k0 = k;
                acc_req = 1'b0;
            end
            if (acc_ack1 && k1 == 0) k1 = k;
        end
        acc_req = 1'b0; acc_vec = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_reset;
        reg_read_check(2'd0, 16'h0000, "R1 cfg reset");
        reg_read_check(2'd1, 16'h0000, "R1 base hi reset");
        reg_read_check(2'd2, 16'h0000, "R1 base lo reset");
        reg_read_check(2'd3, 16'h0000, "R11 unused select");
    endtask

    task automatic t_boot;
        int k0, k1, h;
        run_access(1, 1, 1, 0, '0, k0, k1, h);
        check(k0 == 2, "R6 vector fetch acked, stop 0 at reset", k0, 2);
        check(k1 == 0, "R6 vector fetch blocked, stop 1 at reset", k1, 0);
        run_access(1, 1, 0, 0, '0, k0, k1, h);
        check(k1 == 2, "R6 ordinary fetch acked, stop 1 at reset", k1, 2);
        reg_write(2'd0, 16'h0008);
        reg_read_check(2'd0, 16'h0000, "R6 boot bit read-only");
    endtask

    task automatic t_stop_guard;
        reg_write(2'd0, 16'h00F0);
        reg_read_check(2'd0, 16'h0000, "R2 R5 wait/aspc held while stop 0");
        reg_write(2'd1, 16'h1234);
        reg_read_check(2'd1, 16'h0000, "R5 base hi held while stop 0");
    endtask

    task automatic t_waits;
        int k0, k1, h;
        reg_write(2'd0, 16'h0001);
        reg_read_check(2'd0, 16'h0001, "R11 stop readback");
        reg_write(2'd0, 16'h0041);
        reg_read_check(2'd0, 16'h0041, "R2 wait write accepted");
        run_access(1, 1, 0, 0, '0, k0, k1, h);
        check(k0 == 3, "R9 code 01 four clocks", k0, 3);
        reg_write(2'd0, 16'h0081);
        run_access(1, 0, 0, 0, '0, k0, k1, h);
        check(k0 == 4, "R9 code 10 five clocks", k0, 4);
        reg_write(2'd0, 16'h00C1);
        run_access(1, 1, 0, 0, '0, k0, k1, h);
        check(k0 == 1, "R9 code 11 two clocks", k0, 1);
        check(h == 1, "R10 single ack pulse", h, 1);
        reg_write(2'd1, 16'hBEEF);
        reg_write(2'd2, 16'h5A5A);
        reg_read_check(2'd1, 16'hBEEF, "R5 base hi written when stopped");
        reg_read_check(2'd2, 16'h5A5A, "R5 base lo written when stopped");
    endtask

    task automatic t_space;
        int k0, k1, h;
        reg_write(2'd0, 16'h0011);
        run_access(1, 0, 0, 0, '0, k0, k1, h);
        check(k0 == 0, "R7 data blocked by program-only", k0, 0);
        run_access(1, 1, 0, 0, '0, k0, k1, h);
        check(k0 == 2, "R7 program allowed, code 00 three clocks (R9)", k0, 2);
        reg_write(2'd0, 16'h0021);
        run_access(1, 0, 0, 0, '0, k0, k1, h);
        check(k0 == 2, "R7 upper bit no effect", k0, 2);
        run_access(0, 1, 0, 0, '0, k0, k1, h);
        check(k0 == 0, "R12 miss not acked", k0, 0);
    endtask

    task automatic t_emul;
        int k0, k1, h;
        reg_write(2'd0, 16'h0005);
        reg_read_check(2'd0, 16'h0005, "R8 emul readback");
        run_access(1, 1, 0, 0, '0, k0, k1, h);
        check(k0 == 0, "R8 forced external not acked", k0, 0);
        reg_write(2'd0, 16'h0001);
    endtask

    task automatic t_capture;
        int k0, k1, h;
        reg_write(2'd0, 16'h0081);
        run_access(1, 1, 0, 1, 16'h00C1, k0, k1, h);
        check(k0 == 4, "R10 wait captured at accept", k0, 4);
        check(h == 1, "R10 ack one cycle", h, 1);
        reg_read_check(2'd0, 16'h00C1, "R10 mid-access write landed");
        run_access(1, 1, 0, 0, '0, k0, k1, h);
        check(k0 == 1, "R10 next access uses new code", k0, 1);
    endtask

    task automatic t_lock;
        int k0, k1, h;
        reg_write(2'd0, 16'h0003);
        reg_read_check(2'd0, 16'h0003, "R3 lock set");
        reg_write(2'd0, 16'h0081);
        reg_read_check(2'd0, 16'h0003, "R3 R4 lock kept, wait held");
        reg_write(2'd0, 16'h0021);
        reg_read_check(2'd0, 16'h0003, "R4 aspc held under lock");
        reg_write(2'd1, 16'h0000);
        reg_read_check(2'd1, 16'hBEEF, "R4 base hi held under lock");
        reg_write(2'd2, 16'h0000);
        reg_read_check(2'd2, 16'h5A5A, "R4 base lo held under lock");
        reg_write(2'd0, 16'h0000);
        reg_read_check(2'd0, 16'h0002, "R11 read while locked and not stopped");
        run_access(1, 1, 0, 0, '0, k0, k1, h);
        check(k0 == 2, "R9 locked code 00 timing", k0, 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_boot();
        t_stop_guard();
        t_waits();
        t_space();
        t_emul();
        t_capture();
        t_lock();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule